// File: doc/BRIEF.md
# Two-Level Trigger Event Buffer

This block sits behind one channel of a sampling front end and keeps short windows of the continuous 10-bit sample stream that a two-stage trigger system asks for. A first-level trigger starts a capture of a programmable number of samples into the slot currently open for writing. The capture can reach back into a short history of past samples, or it can begin a programmable number of cycles after the trigger.

A finished capture stays tentative. A second-level trigger confirms it and freezes the slot for readout. If no confirmation comes, the next accepted first-level trigger writes over the same slot. Frozen captures queue in a ring of slots and leave through a valid/ready port, oldest first, one sample per beat, with a marker on the final sample.

When every slot holds a frozen capture, the block raises a busy flag and ignores first-level triggers. It clears the flag once readout frees a slot. Everything runs on one clock.

Top module: `trig_event_buffer`

## Requirements
- R1: Out of reset, rd_valid_o and busy_o are low.
- R2: With pre_mode_i=1, a capture stores cap_len samples, the first of which is the sample presented offset_i cycles before the trigger edge (offset_i 0 to 15, 0 meaning the sample at the trigger edge).
- R3: With pre_mode_i=0, the first stored sample is the one presented offset_i cycles after the trigger edge, and the following samples are consecutive.
- R4: A completed capture that has not been confirmed produces no readout (rd_valid_o stays low) until a second-level trigger arrives, which then freezes it.
- R5: An unconfirmed completed capture is replaced by the next accepted first-level trigger and never appears at the readout port.
- R6: A second-level trigger seen while no capture is pending, or while a capture is still in progress, is remembered and freezes the next capture when it completes.
- R7: A first-level trigger that arrives while a capture is waiting out its delay or writing samples is ignored.
- R8: With all 8 slots frozen, busy_o is high and first-level triggers are ignored. busy_o falls on the clock edge that accepts the final sample of the oldest slot.
- R9: Frozen captures are read out in the order they were frozen. rd_last_o is high on the final sample of each capture. rd_data_o and rd_valid_o hold steady while rd_ready_i is low. A slot is released when its final sample is accepted.
- R10: The capture length is taken from cap_len_i at the accepted trigger. Valid lengths run from 1 to 16. A value of 0 is treated as 1, and a value above 16 is treated as 16.
- R11: If first-level and second-level triggers coincide while a completed capture is pending, the pending capture is frozen and that first-level trigger is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample and readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Processed sample, one per clock |
| l1_trig_i | input | 1 | First-level trigger pulse |
| l2_trig_i | input | 1 | Second-level (confirm) trigger pulse |
| pre_mode_i | input | 1 | 1: offset reaches back in history; 0: offset delays the start |
| offset_i | input | 4 | Pre-trigger depth or post-trigger delay in cycles |
| cap_len_i | input | 5 | Samples per capture |
| busy_o | output | 1 | All slots frozen; first-level triggers ignored |
| rd_valid_o | output | 1 | Readout sample available |
| rd_data_o | output | 10 | Readout sample |
| rd_last_o | output | 1 | Final sample of the current capture |
| rd_ready_i | input | 1 | Readout consumer accepts the sample |

## Verification
The assertions take the trigger inputs to be single-cycle pulses and the configuration to be stable around an accepted trigger. They also take the readout consumer to keep rd_ready_i free of any combinational dependence on rd_valid_o. The stimulus changes triggers, configuration and ready only at the falling clock edge. Each trigger is held for exactly one cycle. Configuration is changed only while no capture is running. Before any pre-trigger capture, the stimulus runs enough idle cycles after reset to fill the history with real samples.

// File: rtl/etb_pkg.sv
package etb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_HOLD
  } cap_st_e;
endpackage

// File: rtl/etb_history.sv
// Circular delay line; DEPTH must be a power of two so the pointer wraps.
module etb_history #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [PTR_W-1:0]  tap_i,
  output logic [DATA_W-1:0] smp_o
);
  logic [DATA_W-1:0] line_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q;
  logic              warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      warm_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else begin
      line_q[wptr_q] <= smp_i;
      wptr_q         <= wptr_q + PTR_W'(1);
      warm_q         <= 1'b1;
    end
  end

  // tap 0 is the live sample, tap k the one k cycles ago
  always_comb begin
    if (tap_i == '0) smp_o = smp_i;
    else             smp_o = line_q[wptr_q - tap_i];
  end

  assert_tap_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && tap_i == PTR_W'(1)) |-> smp_o == $past(smp_i));
endmodule

// File: rtl/etb_capture_ctrl.sv
module etb_capture_ctrl
  import etb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int MAX_LEN   = 16,
  parameter int OFF_W     = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l1_i,
  input  logic              l2_i,
  input  logic              pre_mode_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              full_i,
  output logic [OFF_W-1:0]  tap_o,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              freeze_o,
  output logic [LEN_W-1:0]  freeze_len_o
);
  cap_st_e           st_q;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q, eff_len, cur_len;
  logic [OFF_W-1:0]  tap_q, wait_q;
  logic              l2_seen_q;
  logic              start, done;

  always_comb begin
    if (len_i == '0)                    eff_len = LEN_W'(1);
    else if (len_i > LEN_W'(MAX_LEN))   eff_len = LEN_W'(MAX_LEN);
    else                                eff_len = len_i;

    // in HOLD a coincident confirm wins over a new capture
    start   = l1_i && !full_i && (st_q == ST_IDLE || (st_q == ST_HOLD && !l2_i));
    cur_len = start ? eff_len : len_q;

    wr_en_o  = 1'b0;
    wr_idx_o = idx_q;
    if (start) begin
      if (pre_mode_i || offset_i == '0) begin
        wr_en_o  = 1'b1;
        wr_idx_o = '0;
      end
    end else if (st_q == ST_WAIT && wait_q == OFF_W'(1)) begin
      wr_en_o  = 1'b1;
      wr_idx_o = '0;
    end else if (st_q == ST_RUN) begin
      wr_en_o = 1'b1;
    end

    done     = wr_en_o && (LEN_W'(wr_idx_o) + LEN_W'(1) == cur_len);
    freeze_o = (done && (l2_seen_q || l2_i)) || (st_q == ST_HOLD && l2_i);
    tap_o    = start ? (pre_mode_i ? offset_i : '0) : tap_q;
  end

  assign wr_slot_o    = slot_q;
  assign freeze_len_o = cur_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      slot_q    <= '0;
      idx_q     <= '0;
      len_q     <= LEN_W'(1);
      tap_q     <= '0;
      wait_q    <= '0;
      l2_seen_q <= 1'b0;
    end else begin
      if (freeze_o)
        slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
      l2_seen_q <= freeze_o ? 1'b0 : (l2_seen_q | l2_i);
      if (start) begin
        len_q <= eff_len;
        tap_q <= pre_mode_i ? offset_i : '0;
      end
      if (wr_en_o) begin
        if (done) st_q <= freeze_o ? ST_IDLE : ST_HOLD;
        else begin
          st_q  <= ST_RUN;
          idx_q <= wr_idx_o + IDX_W'(1);
        end
      end else if (start) begin
        st_q   <= ST_WAIT;
        wait_q <= offset_i;
      end else if (st_q == ST_WAIT) begin
        wait_q <= wait_q - OFF_W'(1);
      end else if (st_q == ST_HOLD && l2_i) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assert_freeze_room_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> !full_i);
  assert_full_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && l1_i && full_i && !l2_i) |=> st_q == ST_IDLE);
  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WAIT || st_q == ST_RUN) && l1_i) |=> $stable(len_q) && $stable(tap_q));
endmodule

// File: rtl/etb_slot_store.sv
module etb_slot_store #(
  parameter int DATA_W    = 10,
  parameter int NUM_SLOTS = 8,
  parameter int MAX_LEN   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int DEPTH    = NUM_SLOTS * MAX_LEN,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              len_we_i,
  input  logic [SLOT_W-1:0] len_slot_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LEN_W-1:0]  rd_len_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [LEN_W-1:0]  len_q [NUM_SLOTS];
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign wr_addr = ADDR_W'(wr_slot_i) * ADDR_W'(MAX_LEN) + ADDR_W'(wr_idx_i);
  assign rd_addr = ADDR_W'(rd_slot_i) * ADDR_W'(MAX_LEN) + ADDR_W'(rd_idx_i);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SLOTS; s++) len_q[s] <= LEN_W'(1);
    end else if (len_we_i) begin
      len_q[len_slot_i] <= len_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr];
  assign rd_len_o  = len_q[rd_slot_i];

  assert_len_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_we_i |-> (len_i != '0 && len_i <= LEN_W'(MAX_LEN)));
endmodule

// File: rtl/etb_readout.sv
module etb_readout #(
  parameter int NUM_SLOTS = 8,
  parameter int MAX_LEN   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  input  logic              rd_ready_i,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pop;

  assign rd_valid_o = cnt_q != '0;
  assign rd_last_o  = rd_valid_o && (LEN_W'(idx_q) + LEN_W'(1) == rd_len_i);
  assign pop        = rd_valid_o && rd_ready_i && rd_last_o;
  assign full_o     = cnt_q == CNT_W'(NUM_SLOTS);
  assign rd_slot_o  = slot_q;
  assign rd_idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
      idx_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(freeze_i) - CNT_W'(pop);
      if (rd_valid_o && rd_ready_i) begin
        if (rd_last_o) begin
          idx_q  <= '0;
          slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_SLOTS));
  assert_hold_pos_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o && $stable(idx_q) && $stable(slot_q));
endmodule

// File: rtl/trig_event_buffer.sv
module trig_event_buffer #(
  parameter int DATA_W     = 10,
  parameter int NUM_SLOTS  = 8,
  parameter int MAX_LEN    = 16,
  parameter int HIST_DEPTH = 16,
  localparam int OFF_W     = $clog2(HIST_DEPTH),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int IDX_W     = $clog2(MAX_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              l1_trig_i,
  input  logic              l2_trig_i,
  input  logic              pre_mode_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [LEN_W-1:0]  cap_len_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  input  logic              rd_ready_i
);
  logic [OFF_W-1:0]  tap;
  logic [DATA_W-1:0] hist_smp;
  logic              wr_en, freeze, full;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [LEN_W-1:0]  freeze_len, rd_len;

  etb_history #(.DATA_W(DATA_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk_i (clk_i), .rst_ni(rst_ni), .smp_i(sample_i), .tap_i(tap), .smp_o(hist_smp)
  );

  etb_capture_ctrl #(.NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN), .OFF_W(OFF_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .l1_i        (l1_trig_i),
    .l2_i        (l2_trig_i),
    .pre_mode_i  (pre_mode_i),
    .offset_i    (offset_i),
    .len_i       (cap_len_i),
    .full_i      (full),
    .tap_o       (tap),
    .wr_en_o     (wr_en),
    .wr_slot_o   (wr_slot),
    .wr_idx_o    (wr_idx),
    .freeze_o    (freeze),
    .freeze_len_o(freeze_len)
  );

  etb_slot_store #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_idx_i  (wr_idx),
    .wr_data_i (hist_smp),
    .len_we_i  (freeze),
    .len_slot_i(wr_slot),
    .len_i     (freeze_len),
    .rd_slot_i (rd_slot),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data_o),
    .rd_len_o  (rd_len)
  );

  etb_readout #(.NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .freeze_i  (freeze),
    .rd_len_i  (rd_len),
    .rd_ready_i(rd_ready_i),
    .rd_slot_o (rd_slot),
    .rd_idx_o  (rd_idx),
    .rd_valid_o(rd_valid_o),
    .rd_last_o (rd_last_o),
    .full_o    (full)
  );

  assign busy_o = full;

  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_data_o) && $stable(rd_last_o));
  assert_no_write_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !busy_o);
endmodule

// File: tb/tb_trig_event_buffer.sv
`timescale 1ns/1ps
module tb_trig_event_buffer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] sample_i = '0;
  logic       l1_trig_i = 1'b0, l2_trig_i = 1'b0, pre_mode_i = 1'b1;
  logic [3:0] offset_i = '0;
  logic [4:0] cap_len_i = 5'd4;
  logic       busy_o, rd_valid_o, rd_last_o;
  logic [9:0] rd_data_o;
  logic       rd_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;

  trig_event_buffer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .l1_trig_i(l1_trig_i), .l2_trig_i(l2_trig_i), .pre_mode_i(pre_mode_i),
    .offset_i(offset_i), .cap_len_i(cap_len_i), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_last_o(rd_last_o),
    .rd_ready_i(rd_ready_i)
  );

  int         n_chk = 0, n_bad = 0;
  logic [10:0] exp_q[$];
  string      tag_q[$];
  logic       rd_en = 1'b1;
  logic [9:0] smp = '0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic l1, input logic l2);
    @(negedge clk_i);
    smp = smp + 10'd1;
    sample_i  = smp;
    l1_trig_i = l1;
    l2_trig_i = l2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic cfg(input logic pm, input int off, input int len);
    pre_mode_i = pm;
    offset_i   = 4'(off);
    cap_len_i  = 5'(len);
  endtask

  task automatic push_cap(input logic [9:0] first, input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({(i == len - 1), first + 10'(i)});
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain(input string tag);
    int k = 0;
    while (exp_q.size() != 0 && k < 300) begin
      tick(1'b0, 1'b0);
      k++;
    end
    check(tag, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    idle(2);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      rd_ready_i = rd_en;
      if (rd_valid_o && rd_en) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          n_bad++;
          $display("FAIL R5 R7 R8 unexpected beat: actual=%0h expected=none",
                   {rd_last_o, rd_data_o});
        end else begin
          automatic logic [10:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, {rd_last_o, rd_data_o}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] s;
    repeat (3) @(negedge clk_i);
    check("R1 valid", rd_valid_o, 0);
    check("R1 busy", busy_o, 0);
    rst_ni = 1'b1;
    idle(20);

    // R2 pre-trigger depth 5, R4 invisible until confirm
    cfg(1'b1, 5, 8);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s - 10'd5, 8, "R2");
    idle(10);
    check("R4 pending hidden", rd_valid_o, 0);
    tick(1'b0, 1'b1);
    drain("R2 drain");

    // R3 delay of 7
    cfg(1'b0, 7, 4);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s + 10'd7, 4, "R3");
    idle(14);
    tick(1'b0, 1'b1);
    drain("R3 drain");

    // R5 overwrite
    cfg(1'b1, 0, 3);
    tick(1'b1, 1'b0);
    idle(6);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s, 3, "R5");
    idle(6);
    tick(1'b0, 1'b1);
    drain("R5 drain");

    // R6 confirm together with L1, then confirm mid-capture
    cfg(1'b1, 3, 6);
    tick(1'b1, 1'b1); s = smp;
    push_cap(s - 10'd3, 6, "R6 early");
    idle(10);
    drain("R6 drain a");
    cfg(1'b1, 0, 6);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s, 6, "R6 mid");
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    idle(8);
    drain("R6 drain b");

    // R7 L1 in wait and in run ignored
    cfg(1'b0, 4, 5);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s + 10'd4, 5, "R7");
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    idle(3);
    tick(1'b1, 1'b0);
    idle(8);
    tick(1'b0, 1'b1);
    drain("R7 drain");

    // R10 length corners
    cfg(1'b1, 0, 1);
    tick(1'b1, 1'b1); s = smp;
    push_cap(s, 1, "R10 len1");
    idle(3);
    cfg(1'b1, 15, 16);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s - 10'd15, 16, "R10 len16");
    idle(18);
    tick(1'b0, 1'b1);
    idle(2);
    cfg(1'b1, 0, 0);
    tick(1'b1, 1'b1); s = smp;
    push_cap(s, 1, "R10 len0");
    idle(3);
    cfg(1'b1, 0, 31);
    tick(1'b1, 1'b1); s = smp;
    push_cap(s, 16, "R10 len31");
    idle(20);
    drain("R10 drain");

    // R11 coincident triggers in hold; then a latched confirm (R6)
    cfg(1'b1, 0, 3);
    tick(1'b1, 1'b0); s = smp;
    idle(5);
    tick(1'b1, 1'b1);
    push_cap(s, 3, "R11");
    idle(3);
    tick(1'b0, 1'b1);
    idle(2);
    cfg(1'b1, 2, 4);
    tick(1'b1, 1'b0); s = smp;
    push_cap(s - 10'd2, 4, "R6 latched");
    idle(8);
    drain("R11 drain");

    // R9 order and hold while not ready
    rd_en = 1'b0;
    idle(2);
    cfg(1'b1, 0, 3);
    tick(1'b1, 1'b1); s = smp;
    push_cap(s, 3, "R9 first");
    idle(5);
    tick(1'b1, 1'b1); s = smp;
    push_cap(s, 3, "R9 second");
    idle(5);
    begin
      logic [9:0] d0;
      d0 = rd_data_o;
      check("R9 valid", rd_valid_o, 1);
      idle(3);
      check("R9 data held", rd_data_o, d0);
      check("R9 valid held", rd_valid_o, 1);
    end
    rd_en = 1'b1;
    drain("R9 drain");

    // R8 all slots frozen
    rd_en = 1'b0;
    idle(2);
    cfg(1'b1, 0, 2);
    for (int k = 0; k < 8; k++) begin
      tick(1'b1, 1'b1); s = smp;
      push_cap(s, 2, "R8 slot");
      idle(3);
    end
    check("R8 busy high", busy_o, 1);
    tick(1'b1, 1'b0);
    idle(4);
    check("R8 still busy", busy_o, 1);
    rd_en = 1'b1;
    wait (exp_q.size() <= 14);
    tick(1'b0, 1'b0);
    check("R8 busy released", busy_o, 0);
    drain("R8 drain");
    idle(10);
    check("R8 ignored trigger", rd_valid_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule